// File: doc/BRIEF.md
# PC Card Access Strobe Sequencer

This block runs one card-interface cycle for a chip-select area that is set up as a PC card slot. A request names the address space (common memory, attribute memory or I/O), the direction, the access size and the low address bit. The bus width, setup, hold and wait settings arrive on configuration inputs. The block then steps through four phases: idle, setup, strobe and hold. It drives two active-low card enables and a register-select line. It also drives one of four strobes: output enable, memory write enable, I/O read or I/O write.

The generic write-enable pins of the area are reused. Index 0 carries register select, index 1 carries memory write enable, index 2 carries I/O read and index 3 carries I/O write. The card enables and the register-select line stay asserted from the start of setup to the end of hold. The strobe is asserted only in the strobe phase. A slow card can stretch that phase through the ready input.

Top module: `pcc_strobe_seq`

## Requirements
- R1: While reset is applied and right after it, all active-low outputs are high, and `busy_o`, `done_o` and `err_o` are low.
- R2: A request is accepted only in idle. The card enables and register select are then asserted for exactly `cfg_setup_i` cycles (0 to 15) before the strobe goes active.
- R3: The strobe stays active for at least `cfg_wait_i + 1` cycles (wait count 0 to 25).
- R4: When the wait count is nonzero, `ready_i` low in the last programmed strobe cycle, or in any extension cycle, adds one more strobe cycle.
- R5: When the wait count is zero, `ready_i` is ignored and the strobe lasts exactly one cycle.
- R6: After the strobe, the card enables stay asserted for exactly `cfg_hold_i` cycles (0 to 15). The cycle after that, `busy_o` is low and `done_o` is high for one cycle.
- R7: Width code 0 is 8 bits and code 1 is 16 bits. At 8 bits only `ce_lo_n_o` is asserted. At 16 bits, a word access (size 1) asserts both enables, an even byte (addr0 = 0) asserts only `ce_lo_n_o` and an odd byte asserts only `ce_hi_n_o`.
- R8: `reg_n_o` is low for attribute space (code 1) and I/O space (codes 2 and 3), and high for common space (code 0). It holds steady for the whole access.
- R9: Memory spaces use `oe_n_o` to read and `we_n_o` to write. I/O spaces use `iord_n_o` and `iowr_n_o`. At most one strobe is active at a time.
- R10: A width code of 2 or 3 gives a one-cycle `err_o` pulse in the cycle after the request. No enable or strobe is asserted.
- R11: Requests made while `busy_o` is high have no effect on the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request |
| req_space_i | input | 2 | 0 common, 1 attribute, 2 or 3 I/O |
| req_write_i | input | 1 | 1 write, 0 read |
| req_size_i | input | 1 | 0 byte, 1 word |
| req_addr0_i | input | 1 | Address bit 0 |
| cfg_width_i | input | 2 | Bus width code (0: 8, 1: 16, others invalid) |
| cfg_setup_i | input | 4 | Setup cycles before strobe |
| cfg_hold_i | input | 4 | Hold cycles after strobe |
| cfg_wait_i | input | 5 | Programmed wait cycles |
| ready_i | input | 1 | Card ready, low stretches strobe |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle invalid width pulse |
| ce_lo_n_o | output | 1 | Low card enable |
| ce_hi_n_o | output | 1 | High card enable |
| oe_n_o | output | 1 | Output enable (memory read) |
| we_n_o | output | 1 | Memory write enable |
| reg_n_o | output | 1 | Register select |
| iord_n_o | output | 1 | I/O read strobe |
| iowr_n_o | output | 1 | I/O write strobe |

## Verification
The assertions assume that the configuration inputs hold steady while they are sampled at acceptance, and that wait counts never exceed 25. They also assume that each access is followed by at least one idle cycle before the next request is taken. The phase counter and the register-select stability check rely on that. The bench keeps within these limits: it changes configuration only while the block is idle and drops the request once the access has started. The only request it raises during a busy access is a deliberate intruding one, and it withdraws that request before completion.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } pcc_phase_e;

  localparam logic [1:0] WIDTH_8  = 2'd0;
  localparam logic [1:0] WIDTH_16 = 2'd1;
  localparam logic [1:0] SPACE_COMMON = 2'd0;
endpackage

// File: rtl/pcc_lane_decode.sv
module pcc_lane_decode
  import pcc_pkg::*;
(
  input  logic [1:0] space_i,
  input  logic       size_i,
  input  logic       addr0_i,
  input  logic [1:0] width_i,
  output logic       width_ok_o,
  output logic       lane_lo_o,
  output logic       lane_hi_o,
  output logic       reg_sel_o,
  output logic       io_o
);
  always_comb begin
    width_ok_o = (width_i == WIDTH_8) || (width_i == WIDTH_16);
    if (width_i == WIDTH_16) begin
      lane_lo_o = size_i || !addr0_i;
      lane_hi_o = size_i || addr0_i;
    end else begin
      lane_lo_o = 1'b1;
      lane_hi_o = 1'b0;
    end
    reg_sel_o = (space_i != SPACE_COMMON);
    io_o      = space_i[1];
  end
endmodule

// File: rtl/pcc_phase_ctrl.sv
module pcc_phase_ctrl
  import pcc_pkg::*;
#(
  parameter int TIME_W = 4,
  parameter int WAIT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TIME_W-1:0] setup_i,
  input  logic [TIME_W-1:0] hold_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              ready_i,
  output pcc_phase_e        phase_o,
  output logic              done_o
);
  localparam int CNT_W = (WAIT_W > TIME_W) ? WAIT_W : TIME_W;

  pcc_phase_e        phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TIME_W-1:0] hold_q;
  logic [WAIT_W-1:0] wait_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      hold_q  <= '0;
      wait_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          hold_q <= hold_i;
          wait_q <= wait_i;
          if (setup_i != '0) begin
            phase_q <= PH_SETUP;
            cnt_q   <= CNT_W'(setup_i) - CNT_W'(1);
          end else begin
            phase_q <= PH_STROBE;
            cnt_q   <= CNT_W'(wait_i);
          end
        end
        PH_SETUP: begin
          if (cnt_q == '0) begin
            phase_q <= PH_STROBE;
            cnt_q   <= CNT_W'(wait_q);
          end else cnt_q <= cnt_q - CNT_W'(1);
        end
        PH_STROBE: begin
          if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
          else if (wait_q != '0 && !ready_i) cnt_q <= '0; // card stretches
          else if (hold_q != '0) begin
            phase_q <= PH_HOLD;
            cnt_q   <= CNT_W'(hold_q) - CNT_W'(1);
          end else begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt_q == '0) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else cnt_q <= cnt_q - CNT_W'(1);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign done_o  = done_q;

  assert_strobe_min_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STROBE && cnt_q != '0) |=> (phase_q == PH_STROBE));
  assert_ready_extends_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STROBE && cnt_q == '0 && wait_q != '0 && !ready_i) |=> (phase_q == PH_STROBE));
  assert_ready_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STROBE && cnt_q == '0 && wait_q == '0) |=> (phase_q != PH_STROBE));
  assert_done_after_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (phase_q == PH_IDLE && $past(phase_q) != PH_IDLE));
endmodule

// File: rtl/pcc_strobe_seq.sv
module pcc_strobe_seq
  import pcc_pkg::*;
#(
  parameter int TIME_W = 4,
  parameter int WAIT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_space_i,
  input  logic              req_write_i,
  input  logic              req_size_i,
  input  logic              req_addr0_i,
  input  logic [1:0]        cfg_width_i,
  input  logic [TIME_W-1:0] cfg_setup_i,
  input  logic [TIME_W-1:0] cfg_hold_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic              ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              ce_lo_n_o,
  output logic              ce_hi_n_o,
  output logic              oe_n_o,
  output logic              we_n_o,
  output logic              reg_n_o,
  output logic              iord_n_o,
  output logic              iowr_n_o
);
  pcc_phase_e phase;
  logic width_ok, lane_lo, lane_hi, reg_sel, is_io;
  logic accept, start;
  logic lo_q, hi_q, reg_q, io_q, wr_q, err_q;

  pcc_lane_decode u_decode (
    .space_i   (req_space_i),
    .size_i    (req_size_i),
    .addr0_i   (req_addr0_i),
    .width_i   (cfg_width_i),
    .width_ok_o(width_ok),
    .lane_lo_o (lane_lo),
    .lane_hi_o (lane_hi),
    .reg_sel_o (reg_sel),
    .io_o      (is_io)
  );

  assign accept = req_valid_i && (phase == PH_IDLE);
  assign start  = accept && width_ok;

  pcc_phase_ctrl #(.TIME_W(TIME_W), .WAIT_W(WAIT_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .setup_i(cfg_setup_i),
    .hold_i (cfg_hold_i),
    .wait_i (cfg_wait_i),
    .ready_i(ready_i),
    .phase_o(phase),
    .done_o (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= 1'b0;
      hi_q  <= 1'b0;
      reg_q <= 1'b0;
      io_q  <= 1'b0;
      wr_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= accept && !width_ok;
      if (start) begin
        lo_q  <= lane_lo;
        hi_q  <= lane_hi;
        reg_q <= reg_sel;
        io_q  <= is_io;
        wr_q  <= req_write_i;
      end
    end
  end

  logic active, strobe_on;
  assign active    = (phase != PH_IDLE);
  assign strobe_on = (phase == PH_STROBE);

  assign busy_o    = active;
  assign err_o     = err_q;
  assign ce_lo_n_o = !(active && lo_q);
  assign ce_hi_n_o = !(active && hi_q);
  assign reg_n_o   = !(active && reg_q);
  assign oe_n_o    = !(strobe_on && !io_q && !wr_q);
  assign we_n_o    = !(strobe_on && !io_q && wr_q);
  assign iord_n_o  = !(strobe_on && io_q && !wr_q);
  assign iowr_n_o  = !(strobe_on && io_q && wr_q);

  assert_strobe_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({!oe_n_o, !we_n_o, !iord_n_o, !iowr_n_o}));
  assert_strobe_in_ce_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_n_o || !we_n_o || !iord_n_o || !iowr_n_o) |-> (!ce_lo_n_o || !ce_hi_n_o));
  assert_reg_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(reg_n_o));
  assert_err_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && ce_lo_n_o && ce_hi_n_o));
  assert_busy_ignores_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(ce_lo_n_o) && $stable(ce_hi_n_o)));
endmodule

// File: tb/pcc_strobe_seq_test.sv
module pcc_strobe_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0, req_addr0 = 1'b0, ready = 1'b0;
  logic [1:0] req_space = '0, cfg_width = '0;
  logic [3:0] cfg_setup = '0, cfg_hold = '0;
  logic [4:0] cfg_wait = '0;
  logic busy, done, err, ce_lo_n, ce_hi_n, oe_n, we_n, reg_n, iord_n, iowr_n;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pcc_strobe_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_space_i(req_space),
    .req_write_i(req_write), .req_size_i(req_size), .req_addr0_i(req_addr0),
    .cfg_width_i(cfg_width), .cfg_setup_i(cfg_setup), .cfg_hold_i(cfg_hold),
    .cfg_wait_i(cfg_wait), .ready_i(ready), .busy_o(busy), .done_o(done), .err_o(err),
    .ce_lo_n_o(ce_lo_n), .ce_hi_n_o(ce_hi_n), .oe_n_o(oe_n), .we_n_o(we_n),
    .reg_n_o(reg_n), .iord_n_o(iord_n), .iowr_n_o(iowr_n)
  );

  typedef struct packed {
    logic [1:0] space;
    logic       wr;
    logic       size;
    logic       a0;
    logic [1:0] width;
    logic [3:0] setup;
    logic [3:0] hold;
    logic [4:0] wt;
    logic [2:0] ext;
    logic       lo;
    logic       hi;
    logic       rg;
    logic       er;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b1, 1'b0, 2'd1, 4'd2,  4'd1,  5'd3,  3'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0,  4'd0,  5'd0,  3'd0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{2'd2, 1'b1, 1'b0, 1'b1, 2'd1, 4'd1,  4'd2,  5'd2,  3'd2, 1'b0, 1'b1, 1'b1, 1'b0},
    '{2'd0, 1'b1, 1'b0, 1'b0, 2'd1, 4'd15, 4'd15, 5'd1,  3'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'd3, 1'b0, 1'b1, 1'b0, 2'd1, 4'd3,  4'd0,  5'd4,  3'd5, 1'b1, 1'b1, 1'b1, 1'b0},
    '{2'd1, 1'b1, 1'b0, 1'b1, 2'd0, 4'd1,  4'd1,  5'd0,  3'd0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{2'd0, 1'b0, 1'b0, 1'b0, 2'd2, 4'd1,  4'd1,  5'd1,  3'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{2'd2, 1'b1, 1'b1, 1'b0, 2'd3, 4'd0,  4'd0,  5'd0,  3'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{2'd0, 1'b0, 1'b0, 1'b1, 2'd1, 4'd0,  4'd3,  5'd25, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 4'd4,  4'd4,  5'd0,  3'd0, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one access; intrude raises a conflicting request while busy
  task automatic run(input vec_t v, input bit intrude);
    int n_busy = 0, n_pre = 0, n_strb = 0, n_post = 0, lane_bad = 0, reg_bad = 0;
    int multi = 0, kind = 0, cyc = 0;
    bit seen_done = 0;
    int exp_kind;
    @(negedge clk);
    req_space = v.space; req_write = v.wr; req_size = v.size; req_addr0 = v.a0;
    cfg_width = v.width; cfg_setup = v.setup; cfg_hold = v.hold; cfg_wait = v.wt;
    ready = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (v.er) begin
      check(err === 1'b1, "R10 err pulse", err, 1);
      check(busy === 1'b0 && ce_lo_n && ce_hi_n, "R10 no access", busy, 0);
      @(negedge clk);
      check(err === 1'b0 && oe_n && we_n && iord_n && iowr_n, "R10 pulse ends", err, 0);
      return;
    end
    if (intrude) begin
      req_valid = 1'b1; req_space = 2'd2; req_write = 1'b1; req_size = 1'b1; cfg_width = 2'd1;
    end
    while (!seen_done && cyc < 200) begin
      cyc++;
      if (intrude && cyc == 3) req_valid = 1'b0;
      if (done) seen_done = 1;
      else if (busy) begin
        bit s_on;
        n_busy++;
        s_on = !oe_n || !we_n || !iord_n || !iowr_n;
        if ((!oe_n + !we_n + !iord_n + !iowr_n) > 1) multi++;
        if (ce_lo_n !== !v.lo || ce_hi_n !== !v.hi) lane_bad++;
        if (reg_n !== !v.rg) reg_bad++;
        if (s_on) begin
          n_strb++;
          kind = !oe_n ? 0 : !we_n ? 1 : !iord_n ? 2 : 3;
          if (v.wt != 0 && n_strb == int'(v.wt) + 1 + int'(v.ext)) ready = 1'b1;
        end else if (n_strb == 0) n_pre++;
        else n_post++;
      end
      if (!seen_done) @(negedge clk);
    end
    check(seen_done && !busy, "R6 done pulse", seen_done, 1);
    check(n_pre == int'(v.setup), "R2 setup cycles", n_pre, v.setup);
    check(n_strb == int'(v.wt) + 1 + ((v.wt != 0) ? int'(v.ext) : 0), "R3/R4/R5 strobe cycles",
          n_strb, int'(v.wt) + 1 + ((v.wt != 0) ? int'(v.ext) : 0));
    check(n_post == int'(v.hold), "R6 hold cycles", n_post, v.hold);
    check(lane_bad == 0, "R7 card enables", lane_bad, 0);
    check(reg_bad == 0, "R8 register select", reg_bad, 0);
    exp_kind = (v.space[1] ? 2 : 0) + (v.wr ? 1 : 0);
    check(kind == exp_kind && multi == 0, "R9 strobe kind", kind, exp_kind);
    @(negedge clk);
    check(!done && !busy, "R6 done one cycle", done, 0);
    if (intrude) check(!busy && ce_lo_n && ce_hi_n, "R11 no second access", busy, 0);
    ready = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 0 && done === 0 && err === 0, "R1 reset status", busy, 0);
    check(ce_lo_n && ce_hi_n && oe_n && we_n && reg_n && iord_n && iowr_n,
          "R1 reset strobes", {ce_lo_n, ce_hi_n, oe_n, we_n, reg_n, iord_n, iowr_n}, 127);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 0 && ce_lo_n && reg_n && oe_n, "R1 after reset", busy, 0);

    for (int i = 0; i < NV; i++) run(VECS[i], 1'b0);

    // R11: common-memory read with a conflicting I/O write raised while busy
    run('{2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 4'd4, 4'd1, 5'd2, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0}, 1'b1);
    // R4: long ready extension on a minimal wait count
    run('{2'd1, 1'b1, 1'b1, 1'b0, 2'd1, 4'd0, 4'd0, 5'd1, 3'd7, 1'b1, 1'b1, 1'b1, 1'b0}, 1'b0);

    // R1: reset mid-access returns all lines to idle
    @(negedge clk);
    req_space = 2'd0; cfg_width = 2'd0; cfg_setup = 4'd2; cfg_wait = 5'd3; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!busy && ce_lo_n && oe_n && reg_n, "R1 async reset", busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule